// File: doc/BRIEF.md
# Bidirectional Pin Port with Direction Control

This block is an eight-pin general-purpose I/O port that hangs off a simple CPU register bus. Software owns two registers: an output latch that holds the value to be driven, and a direction register that makes each pin an input or an output one bit at a time. After reset every pin is a high-impedance input. The block does not drive a pad itself. It presents per-bit output-value and output-enable signals to the pad ring, and it receives a pin-level vector back from it.

The port is split by drive type. The low nibble drives open-drain: an output pin pulls low when its latch bit is 0 and lets go when it is 1. The high nibble drives push-pull. Pin levels pass through a two-stage synchronizer before software can see them. A read of the latch address returns, for each bit, either the stored latch value (output pins) or the synchronized pin level (input pins). Because the latch can be written while a pin is still an input, software can preload the value and then flip the direction bit, and the pin starts on the right level.

The bus is a plain register interface, not a stream. A write is one strobe cycle with no wait states. Read data is combinational from the current state whenever the read strobe is high, so there is no back-pressure or handshake to manage.

Top module: `bidir_pin_port`

## Requirements
- R1: After reset the direction register reads 0x00, the latch reads back as 0x00, and no output enable is active.
- R2: A write to address 0x01 loads the latch whatever the direction bits hold; the stored value is visible on readback of any bit whose direction is 1.
- R3: A read of address 0x01 returns, per bit, the latch bit when direction bit = 1 and the synchronized pin level when direction bit = 0.
- R4: Address 0x05 holds the direction register; all eight bits are writable and read back unchanged.
- R5: Bits 3..0 are open-drain: output enable = direction AND NOT latch, and the output value is 0.
- R6: Bits 7..4 are push-pull: output enable = direction bit, and output value = latch bit.
- R7: A pin level becomes visible on readback after exactly two rising clock edges; after one edge the old level is still returned.
- R8: A read of any address other than 0x01 and 0x05 returns 0x00, and a write to such an address changes neither register.
- R9: When the latch is written before a direction bit goes from 0 to 1, the pin outputs take their final value in the first cycle after the direction write, and the enable stays off before that edge.
- R10: A latch write made while a bit is an input does not change what a read returns for that bit.
- R11: While the read strobe is low, read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pin_in | input | 8 | Pin levels from pads |
| pin_out | output | 8 | Value to drive on each pin |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A register write shows on `pin_oe`, `pin_out` and readback in the cycle right after the edge that samples the strobe. The bench therefore drives each write on a falling edge and checks at the next falling edge. A pin change reaches readback two rising edges after it is applied. The synchronizer check reads once after one edge, expecting the old level, and once after the second edge, expecting the new one. Reads are combinational, so each one is sampled a nanosecond after the address and strobe are set, with no clock edge in between.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/port_addr_decode.sv
module port_addr_decode
  import pin_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == DATA_ADDR)     sel = SEL_DATA;
    else if (addr == DIR_ADDR) sel = SEL_DIR;
    else                       sel = SEL_NONE;
  end
endmodule

// File: rtl/port_regs.sv
module port_regs
  import pin_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  reg_sel_e         sel,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= ZERO;
    end else if (wr && sel == SEL_DATA) begin
      latch_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= ZERO;
    end else if (wr && sel == SEL_DIR) begin
      dir_q <= wdata;
    end
  end

  // latch loads on any data write, regardless of direction
  p_latch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DATA) |=> (latch_q == $past(wdata)));

  p_dir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_DIR) |=> (dir_q == $past(wdata)));

  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_DIR) |=> $stable(dir_q));

  p_unmapped_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(latch_q)));
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic             primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pin_in;
  end

  p_first_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |-> (stage_q[0] == $past(pin_in)));

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end

    p_chain_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
      primed_q |-> (stage_q[s] == $past(stage_q[s-1])));
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pin_drive.sv
module pin_drive #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH-1:0] OD_MASK = 8'h0F
) (
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (OD_MASK[i]) begin : g_od
      // open-drain: pull low only, release on latch=1
      assign pin_out[i] = 1'b0;
      assign pin_oe[i]  = dir_q[i] & ~latch_q[i];
    end else begin : g_pp
      assign pin_out[i] = latch_q[i];
      assign pin_oe[i]  = dir_q[i];
    end
  end
endmodule

// File: rtl/bidir_pin_port.sv
module bidir_pin_port
  import pin_port_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05,
  parameter logic [WIDTH-1:0]  OD_MASK   = 8'h0F,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam logic [WIDTH-1:0] PP_MASK = ~OD_MASK;

  reg_sel_e         sel;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_s;
  logic [WIDTH-1:0] data_view;

  port_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) u_dec (
    .addr(bus_addr), .sel(sel)
  );

  port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr),
    .wdata(bus_wdata), .latch_q(latch_q), .dir_q(dir_q)
  );

  pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_s)
  );

  pin_drive #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) u_drive (
    .latch_q(latch_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // per-bit readback select: outputs show latch, inputs show pins
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      data_view[i] = dir_q[i] ? latch_q[i] : pin_s[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_DATA: bus_rdata = data_view;
        SEL_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0));

  p_oe_needs_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & ~dir_q) == '0));

  p_od_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe & OD_MASK & latch_q) == '0) && ((pin_out & OD_MASK) == '0));

  p_pp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & PP_MASK) == (latch_q & PP_MASK)) &&
    ((pin_oe & PP_MASK) == (dir_q & PP_MASK)));

  p_input_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_DATA) |-> ((bus_rdata & ~dir_q) == (pin_s & ~dir_q)));

  p_unmapped_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel == SEL_NONE) |-> (bus_rdata == '0));

  p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/bidir_pin_port_test.sv
`timescale 1ns/1ps
module bidir_pin_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bidir_pin_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] exp_oe(input logic [7:0] dir, input logic [7:0] lat);
    return (dir & 8'hF0) | (dir & ~lat & 8'h0F);
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h05, r); check("R1 dir reset", r, 8'h00);
    check("R1 oe reset", pin_oe, 8'h00);
    wr_reg(8'h05, 8'hFF);
    rd_reg(8'h01, r); check("R1 latch reset", r, 8'h00);
    wr_reg(8'h05, 8'h00);

    // R11 idle read strobe
    bus_addr = 8'h05; bus_rd = 1'b0; #1 check("R11 rd low", bus_rdata, 8'h00);

    // exhaustive sweep over direction values, R2 R3 R4 R5 R6
    for (int d = 0; d < 256; d++) begin
      logic [7:0] lat, pins, dv;
      dv = 8'(d);
      lat = dv ^ 8'h5A;
      pins = ~dv ^ 8'h33;
      pin_in = pins;
      wr_reg(8'h01, lat);
      wr_reg(8'h05, dv);
      check("R5 R6 oe", pin_oe, exp_oe(dv, lat));
      check("R6 out", pin_out, lat & 8'hF0);
      rd_reg(8'h05, r); check("R4 dir readback", r, dv);
      rd_reg(8'h01, r); check("R3 R2 data readback", r, (dv & lat) | (~dv & pins));
    end

    // R7 synchronizer latency
    wr_reg(8'h05, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hA5;
    @(negedge clk);
    rd_reg(8'h01, r); check("R7 one edge", r, 8'h00);
    @(negedge clk);
    rd_reg(8'h01, r); check("R7 two edges", r, 8'hA5);

    // R10 latch write while input leaves readback alone
    wr_reg(8'h01, 8'h3C);
    rd_reg(8'h01, r); check("R10 input unaffected", r, 8'hA5);
    check("R10 no drive", pin_oe, 8'h00);

    // R9 preload then enable: no intermediate value
    wr_reg(8'h01, 8'h96);
    @(negedge clk);
    bus_addr = 8'h05; bus_wdata = 8'hFF; bus_wr = 1'b1;
    #1 check("R9 before edge oe", pin_oe, 8'h00);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 first cycle oe", pin_oe, exp_oe(8'hFF, 8'h96));
    check("R9 first cycle out", pin_out, 8'h90);
    rd_reg(8'h01, r); check("R2 latch visible", r, 8'h96);

    // R8 unmapped addresses
    for (int a = 0; a < 256; a++) begin
      if (a != 1 && a != 5) begin
        wr_reg(8'(a), 8'h00);
        rd_reg(8'(a), r); check("R8 unmapped read", r, 8'h00);
      end
    end
    rd_reg(8'h05, r); check("R8 dir untouched", r, 8'hFF);
    rd_reg(8'h01, r); check("R8 latch untouched", r, 8'h96);

    done = 1'b1;
    finish_run();
  end
endmodule